// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit resolves one operand reference. The caller gives it a 4-bit addressing-mode code, a 12-bit address field, the current program counter and a register number. The unit reads the general register file through one read port. It reads the data memory through a request/valid handshake, making as many reads as the chosen mode needs. It then pulses `done` and presents the effective address, the operand, and how many memory reads it made. The auto-increment mode also writes the bumped index register back through the register file write port.

The controller is a five-state machine:

- `S_IDLE` waits. `start` moves it to `S_CALC` and latches the request.
- `S_CALC` reads the register and does the address arithmetic. It then moves to one of three states:
  - `S_DONE` for an unused code, immediate mode or register mode.
  - `S_PTR` for modes that first fetch a pointer word.
  - `S_OPND` for modes that go straight to the operand read.
- `S_PTR` holds its request until read-valid, then moves to `S_OPND`.
- `S_OPND` holds its request until read-valid, then moves to `S_DONE`.
- `S_DONE` raises `done` for one cycle and returns to `S_IDLE`.

Mode codes:

| Code | Mode |
|------|------|
| 0 | immediate |
| 1 | direct |
| 2 | indirect |
| 3 | register |
| 4 | register-indirect |
| 5 | PC-relative |
| 6 | indexed |
| 7 | displacement |
| 8 | auto-increment indexed |
| 9 | post-indexed |
| 10 | pre-indexed |
| 11 to 15 | unused |

Notation:

- `sx(A)` is the address field sign-extended to 16 bits.
- `zx(A)` is the address field zero-extended to 16 bits.
- `M[x]` is the memory word at address x.
- `reg[R]` is the register selected by `reg_sel`.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `mem_req` and `rf_we` are low. `mem_req` is never high while `busy` is low.
- R2: Code 0 (immediate) gives `ea` = `operand` = sx(A), with 0 memory reads.
- R3: Code 1 (direct) gives `ea` = zx(A) and `operand` = M[ea], with 1 memory read.
- R4: Code 2 (indirect) gives `ea` = M[zx(A)] and `operand` = M[ea], with 2 memory reads.
- R5: Code 3 (register) gives `ea` = 0 and `operand` = reg[R], with 0 reads. Code 4 (register-indirect) gives `ea` = reg[R] and `operand` = M[ea], with 1 read.
- R6: Code 5 (PC-relative) gives `ea` = pc + 1 + sx(A) and `operand` = M[ea], with 1 read.
- R7: Code 6 (indexed) gives `ea` = zx(A) + reg[R]. Code 7 (displacement) gives `ea` = sx(A) + reg[R]. Both give `operand` = M[ea], with 1 read.
- R8: Code 8 (auto-increment) gives `ea` = zx(A) + reg[R] and `operand` = M[ea], with 1 read. It writes reg[R] + 1 to register R in a single one-cycle write, and no other register changes.
- R9: Code 9 (post-indexed) gives `ea` = M[zx(A)] + reg[R]. Code 10 (pre-indexed) gives `ea` = M[zx(A) + reg[R]]. Both give `operand` = M[ea], with 2 reads. No mode reports more than 2 reads.
- R10: Codes 11 to 15 raise `illegal` with `done`. They give `ea` = `operand` = 0 and 0 reads, issue no memory request, and change no register.
- R11: `start` is accepted only in `S_IDLE`. A `start` while busy has no effect on the request in flight or its results.
- R12: While `mem_req` is high, `mem_addr` stays stable until the one-cycle `mem_rvalid` arrives.
- R13: `done` is a one-cycle pulse. `ea`, `operand`, `illegal` and `mem_reads` hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| mode | input | 4 | Addressing-mode code |
| addr_field | input | FW (12) | Instruction address field |
| pc | input | DW (16) | Address of the current instruction |
| reg_sel | input | RAW (3) | Register number |
| busy | output | 1 | High from acceptance through `done` |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unused mode code seen |
| ea | output | DW | Effective address |
| operand | output | DW | Resolved operand |
| mem_reads | output | 2 | Memory reads made for the request |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | DW | Memory read address |
| mem_rvalid | input | 1 | One-cycle read-data valid |
| mem_rdata | input | DW | Memory read data |
| rf_raddr | output | RAW | Register file read address |
| rf_rdata | input | DW | Register file read data, combinational |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RAW | Register file write address |
| rf_wdata | output | DW | Register file write data |

## Verification
Each kind of wrong internal state shows up at the ports in a particular way:

- A wrong state transition changes the read count, for example a two-read mode reporting one read or `done` arriving early. The bench counts read-valid pulses independently, so it sees this at the `done` of the same request.
- A wrong pointer or index latch gives a wrong `ea` or `operand` at that same `done`.
- A stray register write leaves a changed register. The bench compares its whole register file after every request.
- A held request whose address drifts is caught by the checker on the following clock.

Each vector runs with both zero and non-zero memory latency, so timing-dependent faults also appear.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 4;
    localparam int CNT_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        M_IMM   = 4'd0,
        M_DIR   = 4'd1,
        M_IND   = 4'd2,
        M_REG   = 4'd3,
        M_RIND  = 4'd4,
        M_PCREL = 4'd5,
        M_IDX   = 4'd6,
        M_DISP  = 4'd7,
        M_AINC  = 4'd8,
        M_POST  = 4'd9,
        M_PRE   = 4'd10
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CALC,
        S_PTR,
        S_OPND,
        S_DONE
    } state_e;

endpackage

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
    import ea_pkg::*;
#(
    parameter int FW = 12,
    parameter int DW = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [FW-1:0]     field,
    input  logic [DW-1:0]     pc,
    input  logic [DW-1:0]     rval,
    output logic              legal,
    output logic              need_ptr,
    output logic              need_opnd,
    output logic              post_add,
    output logic              wb,
    output logic [DW-1:0]     calc_ea,
    output logic [DW-1:0]     calc_op,
    output logic [DW-1:0]     ptr_addr
);
    localparam int XW = DW - FW;

    logic [DW-1:0] sx, zx;

    assign sx = {{XW{field[FW-1]}}, field};
    assign zx = {{XW{1'b0}}, field};

    always_comb begin
        legal     = 1'b1;
        need_ptr  = 1'b0;
        need_opnd = 1'b0;
        post_add  = 1'b0;
        wb        = 1'b0;
        calc_ea   = '0;
        calc_op   = '0;
        ptr_addr  = zx;
        case (mode)
            M_IMM: begin
                calc_ea = sx;
                calc_op = sx;
            end
            M_DIR: begin
                calc_ea   = zx;
                need_opnd = 1'b1;
            end
            M_IND: begin
                need_ptr  = 1'b1;
                need_opnd = 1'b1;
            end
            M_REG: begin
                calc_op = rval;
            end
            M_RIND: begin
                calc_ea   = rval;
                need_opnd = 1'b1;
            end
            M_PCREL: begin
                calc_ea   = pc + DW'(1) + sx;
                need_opnd = 1'b1;
            end
            M_IDX: begin
                calc_ea   = zx + rval;
                need_opnd = 1'b1;
            end
            M_DISP: begin
                calc_ea   = sx + rval;
                need_opnd = 1'b1;
            end
            M_AINC: begin
                calc_ea   = zx + rval;
                need_opnd = 1'b1;
                wb        = 1'b1;
            end
            M_POST: begin
                need_ptr  = 1'b1;
                need_opnd = 1'b1;
                post_add  = 1'b1;
            end
            M_PRE: begin
                ptr_addr  = zx + rval;
                need_ptr  = 1'b1;
                need_opnd = 1'b1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic legal,
    input  logic need_ptr,
    input  logic need_opnd,
    input  logic mem_rvalid,
    output logic accept,
    output logic in_calc,
    output logic ptr_fire,
    output logic opnd_fire,
    output logic busy,
    output logic done,
    output logic mem_req,
    output logic sel_ptr
);
    state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_CALC;
            S_CALC: begin
                if (!legal)         state_nx = S_DONE;
                else if (need_ptr)  state_nx = S_PTR;
                else if (need_opnd) state_nx = S_OPND;
                else                state_nx = S_DONE;
            end
            S_PTR:  if (mem_rvalid) state_nx = S_OPND;
            S_OPND: if (mem_rvalid) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        accept    = (state == S_IDLE) && start;
        in_calc   = (state == S_CALC);
        ptr_fire  = (state == S_PTR)  && mem_rvalid;
        opnd_fire = (state == S_OPND) && mem_rvalid;
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        mem_req   = (state == S_PTR) || (state == S_OPND);
        sel_ptr   = (state == S_PTR);
    end

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import ea_pkg::*;
#(
    parameter int FW   = 12,
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int RAW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [FW-1:0]     addr_field,
    input  logic [DW-1:0]     pc,
    input  logic [RAW-1:0]    reg_sel,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DW-1:0]     ea,
    output logic [DW-1:0]     operand,
    output logic [1:0]        mem_reads,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    output logic [RAW-1:0]    rf_raddr,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [RAW-1:0]    rf_waddr,
    output logic [DW-1:0]     rf_wdata
);
    logic [MODE_W-1:0] mode_q;
    logic [FW-1:0]     field_q;
    logic [DW-1:0]     pc_q;
    logic [RAW-1:0]    sel_q;
    logic [DW-1:0]     reg_q;
    logic [DW-1:0]     ptr_q;
    logic              post_q;
    logic [DW-1:0]     ea_q, op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ill_q;

    logic legal, need_ptr, need_opnd, post_add, wb;
    logic [DW-1:0] calc_ea, calc_op, ptr_addr;
    logic accept, in_calc, ptr_fire, opnd_fire, sel_ptr;

    ea_addr_gen #(.FW(FW), .DW(DW)) u_gen (
        .mode      (mode_q),
        .field     (field_q),
        .pc        (pc_q),
        .rval      (rf_rdata),
        .legal     (legal),
        .need_ptr  (need_ptr),
        .need_opnd (need_opnd),
        .post_add  (post_add),
        .wb        (wb),
        .calc_ea   (calc_ea),
        .calc_op   (calc_op),
        .ptr_addr  (ptr_addr)
    );

    ea_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .legal      (legal),
        .need_ptr   (need_ptr),
        .need_opnd  (need_opnd),
        .mem_rvalid (mem_rvalid),
        .accept     (accept),
        .in_calc    (in_calc),
        .ptr_fire   (ptr_fire),
        .opnd_fire  (opnd_fire),
        .busy       (busy),
        .done       (done),
        .mem_req    (mem_req),
        .sel_ptr    (sel_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            field_q <= '0;
            pc_q    <= '0;
            sel_q   <= '0;
            reg_q   <= '0;
            ptr_q   <= '0;
            post_q  <= 1'b0;
            ea_q    <= '0;
            op_q    <= '0;
            cnt_q   <= '0;
            ill_q   <= 1'b0;
        end else begin
            if (accept) begin
                mode_q  <= mode;
                field_q <= addr_field;
                pc_q    <= pc;
                sel_q   <= reg_sel;
                cnt_q   <= '0;
                ill_q   <= 1'b0;
            end
            if (in_calc) begin
                reg_q  <= rf_rdata;
                ptr_q  <= ptr_addr;
                post_q <= post_add;
                ea_q   <= calc_ea;
                op_q   <= calc_op;
                ill_q  <= !legal;
            end
            if (ptr_fire) begin
                ea_q  <= post_q ? (mem_rdata + reg_q) : mem_rdata;
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (opnd_fire) begin
                op_q  <= mem_rdata;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign mem_addr  = sel_ptr ? ptr_q : ea_q;
    assign rf_raddr  = sel_q;
    assign rf_we     = in_calc && legal && wb;
    assign rf_waddr  = sel_q;
    assign rf_wdata  = rf_rdata + DW'(1);
    assign ea        = ea_q;
    assign operand   = op_q;
    assign mem_reads = cnt_q;
    assign illegal   = ill_q;

endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          illegal,
    input logic [DW-1:0] ea,
    input logic [DW-1:0] operand,
    input logic [1:0]    mem_reads,
    input logic          mem_req,
    input logic [DW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          rf_we
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we && !done));

    p_reads_max_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_reads <= 2'd2));

    p_illegal_noread_r10: assert property (@(posedge clk) disable iff (rst)
        (done && illegal) |-> (mem_reads == 2'd0));

    p_we_single_r8: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);

    p_addr_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(ea) && $stable(operand)
                                     && $stable(mem_reads) && $stable(illegal)));

endmodule

bind eff_addr_unit eff_addr_unit_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .ea         (ea),
    .operand    (operand),
    .mem_reads  (mem_reads),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .rf_we      (rf_we)
);

// File: tb/sim_eff_addr_unit.sv
module sim_eff_addr_unit;

    localparam int FW = 12;
    localparam int DW = 16;
    localparam int NREG = 8;
    localparam int RAW = 3;
    localparam int NV = 15;

    // mode, field, pc, reg, expected reads, expected illegal
    localparam logic [37:0] VEC [NV] = '{
        {4'd0,  12'h805, 16'd0,   3'd0, 2'd0, 1'b0},
        {4'd0,  12'h07F, 16'd0,   3'd0, 2'd0, 1'b0},
        {4'd1,  12'h010, 16'd0,   3'd0, 2'd1, 1'b0},
        {4'd2,  12'h021, 16'd0,   3'd0, 2'd2, 1'b0},
        {4'd3,  12'h000, 16'd0,   3'd3, 2'd0, 1'b0},
        {4'd4,  12'h000, 16'd0,   3'd5, 2'd1, 1'b0},
        {4'd5,  12'hFA5, 16'd620, 3'd0, 2'd1, 1'b0},
        {4'd5,  12'h010, 16'h100, 3'd0, 2'd1, 1'b0},
        {4'd6,  12'h800, 16'd0,   3'd2, 2'd1, 1'b0},
        {4'd7,  12'hFF0, 16'd0,   3'd6, 2'd1, 1'b0},
        {4'd8,  12'h004, 16'd0,   3'd4, 2'd1, 1'b0},
        {4'd9,  12'h030, 16'd0,   3'd1, 2'd2, 1'b0},
        {4'd10, 12'h040, 16'd0,   3'd7, 2'd2, 1'b0},
        {4'd11, 12'h123, 16'd0,   3'd2, 2'd0, 1'b1},
        {4'd15, 12'h456, 16'd0,   3'd5, 2'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [3:0] mode = '0;
    logic [FW-1:0] addr_field = '0;
    logic [DW-1:0] pc = '0;
    logic [RAW-1:0] reg_sel = '0;
    logic busy, done, illegal, mem_req, rf_we;
    logic [DW-1:0] ea, operand, mem_addr, rf_wdata, rf_rdata;
    logic [1:0] mem_reads;
    logic mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [RAW-1:0] rf_raddr, rf_waddr;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] snap [NREG];
    int lat = 0;
    int wcnt = 0;
    int seen = 0;
    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int dones = 0;

    always #10 clk = ~clk;

    eff_addr_unit u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .addr_field(addr_field), .pc(pc), .reg_sel(reg_sel),
        .busy(busy), .done(done), .illegal(illegal), .ea(ea),
        .operand(operand), .mem_reads(mem_reads), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    assign rf_rdata = regs[rf_raddr];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rf_we) regs[rf_waddr] <= rf_wdata;
        if (done) dones <= dones + 1;
    end

    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[mem_addr[7:0]];
                wcnt = 0;
                seen = seen + 1;
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    function automatic logic [DW-1:0] rd(input logic [DW-1:0] a);
        return mem[a[7:0]];
    endfunction

    task automatic ref_calc(input logic [3:0] m, input logic [11:0] a,
                            input logic [15:0] p, input logic [2:0] s,
                            output logic [15:0] e, output logic [15:0] o);
        logic [15:0] sx, zx, r;
        sx = {{4{a[11]}}, a};
        zx = {4'b0, a};
        r  = regs[s];
        o  = '0;
        case (m)
            4'd0:  begin e = sx; o = sx; end
            4'd1:  e = zx;
            4'd2:  e = rd(zx);
            4'd3:  begin e = '0; o = r; end
            4'd4:  e = r;
            4'd5:  e = p + 16'd1 + sx;
            4'd6:  e = zx + r;
            4'd7:  e = sx + r;
            4'd8:  e = zx + r;
            4'd9:  e = rd(zx) + r;
            4'd10: e = rd(zx + r);
            default: e = '0;
        endcase
        if (m inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10})
            o = rd(e);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] m, input logic [11:0] a,
                       input logic [15:0] p, input logic [2:0] s, output bit ok);
        int t;
        mode = m; addr_field = a; pc = p; reg_sel = s;
        seen = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        ok = done;
        if (!ok) check("watchdog", 32'd0, 32'd1);
    endtask

    task automatic run_vec(input logic [37:0] v);
        logic [3:0] m; logic [11:0] a; logic [15:0] p; logic [2:0] s;
        logic [1:0] xc; logic xi;
        logic [15:0] e, o;
        bit ok;
        string tag;
        {m, a, p, s, xc, xi} = v;
        case (m)
            4'd0: tag = "R2"; 4'd1: tag = "R3"; 4'd2: tag = "R4";
            4'd3, 4'd4: tag = "R5"; 4'd5: tag = "R6";
            4'd6, 4'd7: tag = "R7"; 4'd8: tag = "R8";
            4'd9, 4'd10: tag = "R9"; default: tag = "R10";
        endcase
        ref_calc(m, a, p, s, e, o);
        for (int i = 0; i < NREG; i++) snap[i] = regs[i];
        if (m == 4'd8) snap[s] = regs[s] + 16'd1;
        run(m, a, p, s, ok);
        if (ok) begin
            check({tag, " ea"}, 32'(ea), 32'(e));
            check({tag, " operand"}, 32'(operand), 32'(o));
            check({tag, " reads"}, 32'(mem_reads), 32'(xc));
            check({tag, " rvalid count"}, 32'(seen), 32'(xc));
            check({tag, " illegal"}, 32'(illegal), 32'(xi));
        end
        @(negedge clk);
        for (int i = 0; i < NREG; i++)
            check({tag, " regfile"}, 32'(regs[i]), 32'(snap[i]));
    endtask

    initial begin
        bit ok;
        logic [15:0] e1, o1;
        int d0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 3);
        for (int i = 0; i < NREG; i++) regs[i] <= 16'(i * 9 + 2);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 rf_we", 32'(rf_we), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int l = 0; l < 3; l += 2) begin
            lat = l;
            for (int k = 0; k < NV; k++) run_vec(VEC[k]);
        end

        // R6: known-answer backward branch, 620 + 1 - 91 = 530
        ref_calc(4'd5, 12'hFA5, 16'd620, 3'd0, e1, o1);
        check("R6 known ea", 32'(e1), 32'd530);

        // R8: two auto-increments on the same register chain
        lat = 1;
        run_vec({4'd8, 12'h002, 16'd0, 3'd6, 2'd1, 1'b0});
        run_vec({4'd8, 12'h002, 16'd0, 3'd6, 2'd1, 1'b0});

        // R11 and R13: start while busy is ignored, results held after done
        lat = 4;
        ref_calc(4'd2, 12'h021, 16'd0, 3'd0, e1, o1);
        mode = 4'd2; addr_field = 12'h021; reg_sel = 3'd0; seen = 0;
        d0 = dones;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        mode = 4'd0; addr_field = 12'h7FF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check("R11 ea", 32'(ea), 32'(e1));
        check("R11 operand", 32'(operand), 32'(o1));
        check("R11 reads", 32'(mem_reads), 2);
        check("R13 single done", 32'(dones - d0), 1);
        check("R13 held ea", 32'(ea), 32'(e1));
        check("R12 rvalid count", 32'(seen), 2);

        // R10 after a real result: illegal clears outputs to zero
        lat = 0;
        run_vec({4'd12, 12'hABC, 16'd0, 3'd1, 2'd0, 1'b1});
        check("R10 ea zero", 32'(ea), 0);
        check("R10 no request", 32'(seen), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule